// File: doc/BRIEF.md
# Packed Integer Pack, Interleave and Lane-Shift Unit

This block rearranges packed integers held in a 64-bit word. It narrows signed elements to half their width with saturation, interleaves elements taken from two source words (from their lower or upper halves), and shifts every lane left or right by one scalar count. A shift never lets a bit move into a neighbouring lane.

Each operation is requested for one cycle by raising `in_valid` together with an opcode, an element-size code, two source words and a shift count. The result is registered. It appears one cycle later, qualified by `out_valid`. In a cycle without `in_valid` the inputs are ignored and the previous result stays on the output. The data width is a parameter and must be a multiple of 64. The shift count width is also a parameter.

Encodings used throughout:
- `opcode`: 0 = pack, 1 = interleave low, 2 = interleave high, 3 = logical left shift, 4 = logical right shift, 5 = arithmetic right shift, 6 and 7 are reserved.
- `elem_size`: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.

Top module: `simd_shuffle_unit`

## Requirements
- R1: Pack (opcode 0) takes signed source elements of 16 bits (elem_size 1) or 32 bits (elem_size 2) and narrows each one to half its width. Source lane i of src_a goes to narrow lane i of the low half of the result. Source lane i of src_b goes to narrow lane i of the high half. A value that fits the narrow signed range is copied unchanged.
- R2: In pack, a source value above the narrow signed maximum becomes that maximum (0x7F or 0x7FFF). A value below the narrow signed minimum becomes that minimum (0x80 or 0x8000).
- R3: Interleave low (opcode 1) works on element sizes 8, 16 and 32 (elem_size 0, 1, 2), with N lanes per word. For k below N/2, result element 2k is src_a element k and result element 2k+1 is src_b element k.
- R4: Interleave high (opcode 2) builds the same pattern from the upper halves. Result element 2k is src_a element N/2+k and element 2k+1 is src_b element N/2+k.
- R5: Logical left shift (opcode 3) and logical right shift (opcode 4) act on lanes of 16, 32 or 64 bits (elem_size 1, 2, 3). Vacated bits are filled with zeros, and no bit crosses a lane boundary.
- R6: Arithmetic right shift (opcode 5) acts on 16-bit or 32-bit lanes (elem_size 1, 2). Vacated bits are filled with a copy of each lane's own sign bit.
- R7: When the shift count is equal to or larger than the lane width, a logical shift gives zero in every lane and an arithmetic shift fills every lane with its sign bit.
- R8: A combination that is not supported gives an all-zero result. These are: pack with elem_size 0 or 3, interleave with elem_size 3, any shift with elem_size 0, arithmetic shift with elem_size 3, and opcodes 6 and 7.
- R9: out_valid equals in_valid delayed by one clock. The result of an operation accepted at one rising edge is presented from that edge on.
- R10: While in_valid is low, every other input is ignored and result keeps its last value.
- R11: After reset, out_valid is 0 and result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request for this cycle |
| opcode | input | 3 | Operation code |
| elem_size | input | 2 | Element size code |
| src_a | input | DW | First source word |
| src_b | input | DW | Second source word |
| shamt | input | CNT_W | Shift count, unsigned |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| result | output | DW | Registered result |

## Verification
The bench uses the default parameters: DW = 64 and CNT_W = 8. An 8-bit count can reach 255, which is past the width of every lane, so R7 is exercised at widths 16, 32 and 64. It is also tested exactly at each width and at width minus one. With a 64-bit word, every lane count named in the requirements is reached: four and two source lanes for pack, eight, four and two lanes for interleave. Saturation is driven on both sides of the range, and every reserved opcode and unsupported size is issued among the valid operations.

// File: rtl/simd_shuffle_pkg.sv
package simd_shuffle_pkg;

   typedef enum logic [2:0] {
      OPC_PACK   = 3'd0,
      OPC_ILV_LO = 3'd1,
      OPC_ILV_HI = 3'd2,
      OPC_SHL    = 3'd3,
      OPC_SHR    = 3'd4,
      OPC_SAR    = 3'd5
   } shuf_op_e;

   typedef enum logic [1:0] {
      ESZ_8  = 2'd0,
      ESZ_16 = 2'd1,
      ESZ_32 = 2'd2,
      ESZ_64 = 2'd3
   } elem_sz_e;

   localparam int unsigned NUM_SIZES = 4;

   function automatic int unsigned size_bits(input int unsigned code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/simd_sat_narrow.sv
module simd_sat_narrow #(
   parameter int unsigned DW = 64,
   parameter int unsigned SW = 16
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] packed_o
);
   localparam int unsigned HW    = SW / 2;
   localparam int unsigned LANES = DW / SW;

   if (SW < 16 || (SW % 16) != 0 || (DW % SW) != 0) begin : g_bad_cfg
      $error("simd_sat_narrow: SW must be a multiple of 16 dividing DW");
   end

   for (genvar s = 0; s < 2; s++) begin : g_src
      logic [DW-1:0] src;
      assign src = (s == 0) ? a_i : b_i;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [SW-1:0] elem;
         logic [HW-1:0] narrow;
         logic          in_range;
         assign elem = src[i*SW +: SW];
         // value fits when all bits from the narrow sign bit upward agree
         assign in_range = (elem[SW-1:HW-1] == '0) || (elem[SW-1:HW-1] == '1);
         always_comb begin
            if (in_range)       narrow = elem[HW-1:0];
            else if (elem[SW-1]) narrow = {1'b1, {(HW-1){1'b0}}};
            else                narrow = {1'b0, {(HW-1){1'b1}}};
         end
         assign packed_o[s*(DW/2) + i*HW +: HW] = narrow;

         always_comb begin
            if (in_range) begin
               AST_PACK_EXACT: assert ({{HW{narrow[HW-1]}}, narrow} == elem)
                  else $error("narrowed lane differs from in-range source"); // R1
            end
            if (!in_range) begin
               AST_PACK_CLAMP: assert (narrow[HW-1] == elem[SW-1])
                  else $error("saturated lane has wrong sign"); // R2
            end
         end
      end
   end
endmodule

// File: rtl/simd_interleave.sv
module simd_interleave #(
   parameter int unsigned DW = 64,
   parameter int unsigned EW = 8
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] lo_o,
   output logic [DW-1:0] hi_o
);
   localparam int unsigned LANES = DW / EW;
   localparam int unsigned HALF  = LANES / 2;

   if (LANES < 2 || (DW % EW) != 0) begin : g_bad_cfg
      $error("simd_interleave: need at least two lanes of EW in DW");
   end

   for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign lo_o[(2*k)*EW   +: EW] = a_i[k*EW +: EW];
      assign lo_o[(2*k+1)*EW +: EW] = b_i[k*EW +: EW];
      assign hi_o[(2*k)*EW   +: EW] = a_i[(HALF+k)*EW +: EW];
      assign hi_o[(2*k+1)*EW +: EW] = b_i[(HALF+k)*EW +: EW];
   end
endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter #(
   parameter int unsigned DW    = 64,
   parameter int unsigned LW    = 16,
   parameter int unsigned CNT_W = 8
) (
   input  logic [DW-1:0]    src_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [DW-1:0]    shl_o,
   output logic [DW-1:0]    shr_o,
   output logic [DW-1:0]    sar_o
);
   localparam int unsigned LANES = DW / LW;
   localparam int unsigned AMT_W = $clog2(LW);
   localparam int unsigned CMP_W = (CNT_W > AMT_W + 1) ? CNT_W : AMT_W + 1;
   localparam logic [CMP_W-1:0] LIMIT = CMP_W'(LW);

   if ((DW % LW) != 0 || (1 << AMT_W) != LW) begin : g_bad_cfg
      $error("simd_lane_shifter: LW must be a power of two dividing DW");
   end

   logic             flush;
   logic [AMT_W-1:0] amt;
   logic [AMT_W-1:0] sar_amt;

   assign flush   = CMP_W'(count_i) >= LIMIT;
   assign amt     = count_i[AMT_W-1:0];
   assign sar_amt = flush ? AMT_W'(LW - 1) : amt;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LW-1:0] lane;
      logic [LW-1:0] l_shl;
      logic [LW-1:0] l_shr;
      logic [LW-1:0] l_sar;
      assign lane  = src_i[i*LW +: LW];
      assign l_shl = flush ? '0 : (lane << amt);
      assign l_shr = flush ? '0 : (lane >> amt);
      assign l_sar = LW'($signed(lane) >>> sar_amt);
      assign shl_o[i*LW +: LW] = l_shl;
      assign shr_o[i*LW +: LW] = l_shr;
      assign sar_o[i*LW +: LW] = l_sar;

      always_comb begin
         if (flush) begin
            AST_SAR_FILL: assert (l_sar == {LW{lane[LW-1]}})
               else $error("oversized arithmetic shift not sign filled"); // R7
         end
         AST_SAR_TOP: assert (l_sar[LW-1] == lane[LW-1])
            else $error("arithmetic shift changed the lane sign"); // R6
      end
   end
endmodule

// File: rtl/simd_shuffle_unit.sv
module simd_shuffle_unit
   import simd_shuffle_pkg::*;
#(
   parameter int unsigned DW    = 64,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       opcode,
   input  logic [1:0]       elem_size,
   input  logic [DW-1:0]    src_a,
   input  logic [DW-1:0]    src_b,
   input  logic [CNT_W-1:0] shamt,
   output logic             out_valid,
   output logic [DW-1:0]    result
);
   if (DW < 64 || (DW % 64) != 0) begin : g_bad_dw
      $error("simd_shuffle_unit: DW must be a non-zero multiple of 64");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("simd_shuffle_unit: CNT_W must be at least 1");
   end

   logic [DW-1:0] pack_r  [NUM_SIZES];
   logic [DW-1:0] ilv_lo  [NUM_SIZES];
   logic [DW-1:0] ilv_hi  [NUM_SIZES];
   logic [DW-1:0] shl_r   [NUM_SIZES];
   logic [DW-1:0] shr_r   [NUM_SIZES];
   logic [DW-1:0] sar_r   [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int unsigned EW = size_bits(g);

      // pack: only 16- and 32-bit sources
      if (g == 1 || g == 2) begin : g_pack
         simd_sat_narrow #(.DW(DW), .SW(EW)) u_pack (
            .a_i      (src_a),
            .b_i      (src_b),
            .packed_o (pack_r[g])
         );
      end else begin : g_no_pack
         assign pack_r[g] = '0;
      end

      // interleave: 8, 16, 32-bit elements
      if (g <= 2) begin : g_ilv
         simd_interleave #(.DW(DW), .EW(EW)) u_ilv (
            .a_i  (src_a),
            .b_i  (src_b),
            .lo_o (ilv_lo[g]),
            .hi_o (ilv_hi[g])
         );
      end else begin : g_no_ilv
         assign ilv_lo[g] = '0;
         assign ilv_hi[g] = '0;
      end

      // shifts: 16, 32, 64-bit lanes; arithmetic only below 64
      if (g >= 1) begin : g_shift
         logic [DW-1:0] sar_raw;
         simd_lane_shifter #(.DW(DW), .LW(EW), .CNT_W(CNT_W)) u_shift (
            .src_i   (src_a),
            .count_i (shamt),
            .shl_o   (shl_r[g]),
            .shr_o   (shr_r[g]),
            .sar_o   (sar_raw)
         );
         if (g <= 2) begin : g_sar_keep
            assign sar_r[g] = sar_raw;
         end else begin : g_sar_drop
            logic unused_sar;
            assign unused_sar = ^sar_raw;
            assign sar_r[g]   = '0;
         end
      end else begin : g_no_shift
         assign shl_r[g] = '0;
         assign shr_r[g] = '0;
         assign sar_r[g] = '0;
      end
   end

   logic [DW-1:0] next_result;

   always_comb begin
      unique case (opcode)
         OPC_PACK:   next_result = pack_r[elem_size];
         OPC_ILV_LO: next_result = ilv_lo[elem_size];
         OPC_ILV_HI: next_result = ilv_hi[elem_size];
         OPC_SHL:    next_result = shl_r[elem_size];
         OPC_SHR:    next_result = shr_r[elem_size];
         OPC_SAR:    next_result = sar_r[elem_size];
         default:    next_result = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_result;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("out_valid missing"); // R9
   AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("spurious out_valid"); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)) else $error("result moved while idle"); // R10
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode > 3'd5) |=> (result == '0)) else $error("reserved opcode gave data"); // R8
   AST_SAR64_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 3'd5 && elem_size == 2'd3) |=> (result == '0))
      else $error("64-bit arithmetic shift gave data"); // R8
endmodule

// File: tb/simd_shuffle_unit_test.sv
module simd_shuffle_unit_test;
   localparam int DW    = 64;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [2:0]       opcode = '0;
   logic [1:0]       elem_size = '0;
   logic [DW-1:0]    src_a = '0;
   logic [DW-1:0]    src_b = '0;
   logic [CNT_W-1:0] shamt = '0;
   logic             out_valid;
   logic [DW-1:0]    result;

   always #10 clk = ~clk;   // 50 MHz

   simd_shuffle_unit #(.DW(DW), .CNT_W(CNT_W)) uut (
      .clk, .rst_n, .in_valid, .opcode, .elem_size,
      .src_a, .src_b, .shamt, .out_valid, .result
   );

   int checks = 0;
   int errors = 0;
   logic          exp_valid = 1'b0;
   logic [63:0]   exp_res = '0;
   string         exp_tag = "R11";

   // behavioural reference, bit by bit
   function automatic logic [63:0] model(int op, int esz, logic [63:0] a,
                                         logic [63:0] b, int sh);
      logic [63:0] r = '0;
      int w = 8 << esz;
      int n = 64 / w;
      case (op)
         0: begin
            if (esz == 1 || esz == 2) begin
               int hw = w / 2;
               int lim = (1 << (hw - 1));
               for (int s = 0; s < 2; s++) begin
                  for (int i = 0; i < n; i++) begin
                     longint v = 0;
                     logic [63:0] src = (s == 0) ? a : b;
                     for (int j = 0; j < w; j++)
                        if (src[i*w + j]) v += (j == w - 1) ? -(longint'(1) << j) : (longint'(1) << j);
                     if (v > lim - 1) v = lim - 1;
                     if (v < -lim) v = -lim;
                     for (int j = 0; j < hw; j++)
                        r[s*32 + i*hw + j] = v[j];
                  end
               end
            end
         end
         1, 2: begin
            if (esz <= 2) begin
               int base = (op == 2) ? n / 2 : 0;
               for (int k = 0; k < n / 2; k++)
                  for (int j = 0; j < w; j++) begin
                     r[(2*k)*w + j]   = a[(base + k)*w + j];
                     r[(2*k+1)*w + j] = b[(base + k)*w + j];
                  end
            end
         end
         3, 4, 5: begin
            if (esz >= 1 && !(op == 5 && esz == 3)) begin
               for (int i = 0; i < n; i++) begin
                  logic sign = a[i*w + w - 1];
                  for (int j = 0; j < w; j++) begin
                     if (op == 3)
                        r[i*w + j] = (j >= sh) ? a[i*w + j - sh] : 1'b0;
                     else if (op == 4)
                        r[i*w + j] = (j + sh < w) ? a[i*w + j + sh] : 1'b0;
                     else
                        r[i*w + j] = (j + sh < w) ? a[i*w + j + sh] : sign;
                  end
               end
            end
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(int op, int esz, int sh);
      int w = 8 << esz;
      if (op > 5) return "R8";
      case (op)
         0: return (esz == 1 || esz == 2) ? "R1,R2" : "R8";
         1: return (esz <= 2) ? "R3" : "R8";
         2: return (esz <= 2) ? "R4" : "R8";
         3, 4: begin
            if (esz == 0) return "R8";
            return (sh >= w) ? "R7" : "R5";
         end
         default: begin
            if (esz == 0 || esz == 3) return "R8";
            return (sh >= w) ? "R7" : "R6";
         end
      endcase
   endfunction

   task automatic check_outputs();
      checks++;
      if (out_valid !== exp_valid) begin
         errors++;
         $display("FAIL R9 out_valid actual %0b expected %0b", out_valid, exp_valid);
      end
      checks++;
      if (result !== exp_res) begin
         errors++;
         $display("FAIL %s result actual %h expected %h", exp_tag, result, exp_res);
      end
   endtask

   task automatic issue(int op, int esz, logic [63:0] a, logic [63:0] b, int sh);
      @(negedge clk);
      check_outputs();
      in_valid  = 1'b1;
      opcode    = 3'(op);
      elem_size = 2'(esz);
      src_a     = a;
      src_b     = b;
      shamt     = 8'(sh);
      exp_valid = 1'b1;
      exp_res   = model(op, esz, a, b, sh);
      exp_tag   = tag_of(op, esz, sh);
   endtask

   // R10: inputs wiggle while idle, result must hold
   task automatic idle(logic [63:0] junk);
      @(negedge clk);
      check_outputs();
      in_valid  = 1'b0;
      opcode    = junk[2:0];
      elem_size = junk[4:3];
      src_a     = junk;
      src_b     = ~junk;
      shamt     = junk[15:8];
      exp_valid = 1'b0;
      exp_tag   = "R10";
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      repeat (3) begin
         @(negedge clk);
         check_outputs();
      end
      rst_n = 1'b1;

      // R1/R2 pack, 16 -> 8 and 32 -> 16, saturating both ways
      issue(0, 1, 64'h7FFF_8000_0080_FF7F, 64'h0012_FFEE_007F_FF80, 0);
      issue(0, 2, 64'h0001_0000_FFFE_FFFF, 64'h0000_7FFF_8000_1234, 0);
      issue(0, 2, 64'h7FFF_FFFF_8000_0000, 64'hFFFF_8000_FFFF_7FFF, 0);
      idle(64'hDEAD_BEEF_0BAD_F00D);
      idle(64'h1234_5678_9ABC_DEF0);
      // R3/R4 interleave at each size
      for (int e = 0; e < 3; e++) begin
         issue(1, e, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 0);
         issue(2, e, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 0);
      end
      // R5/R6/R7 shift counts around each lane width
      for (int e = 1; e < 4; e++) begin
         int w = 8 << e;
         int shs[6] = '{0, 1, w - 1, w, w + 1, 255};
         foreach (shs[i]) begin
            issue(3, e, 64'h8421_F00F_0123_C001, '0, shs[i]);
            issue(4, e, 64'h8421_F00F_0123_C001, '0, shs[i]);
            issue(5, e, 64'h8421_700F_8123_4001, '0, shs[i]);
         end
      end
      // R8 unsupported combinations
      issue(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
      issue(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
      issue(1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
      issue(3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1);
      issue(5, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1);
      issue(6, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1);
      issue(7, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1);

      // mixed random traffic with idle gaps
      for (int t = 0; t < 1500; t++) begin
         logic [63:0] ra = {$urandom(), $urandom()};
         logic [63:0] rb = {$urandom(), $urandom()};
         int rsel = $urandom_range(0, 9);
         int rsh  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 70);
         if (rsel == 9) idle(ra);
         else issue($urandom_range(0, 7), $urandom_range(0, 3), ra, rb, rsh);
      end
      idle(64'h0);
      @(negedge clk);
      check_outputs();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule